// File: doc/BRIEF.md
# Scaled Half-Precision to 8-bit Float Narrowing Packer

This block takes two equal-width vectors of IEEE half-precision values and narrows every element to an 8-bit floating-point byte. Before rounding, each element is multiplied by two raised to a signed 5-bit exponent. A single format bit picks one of two byte encodings: 5 exponent bits with 2 mantissa bits, or 4 exponent bits with 3 mantissa bits. The bytes from both sources are packed into one result vector with the same total width as one source. The first source fills the low half and the second fills the high half.

The sources are intended to be an even/odd register pair. The block has no per-lane enables, so every result byte is written on each accepted operation. The conversion is combinational in per-lane converters, followed by one register stage. The result therefore appears one clock after the input is accepted and holds until the next accepted input.

Top module: `fp8_narrow_pack`

## Requirements
- R1: With NE = VL/16 elements per source, element e of `src_lo` (bits 16e+15:16e) lands in result byte e, and element e of `src_hi` lands in result byte NE+e. Every byte is written on each accepted operation.
- R2: Before rounding, each element is scaled by 2^s. Here s is `scale_exp` read as a two's-complement value in the range -16 to +15.
- R3: `fmt_sel`=0 yields sign/5-bit exponent (bias 15)/2-bit mantissa. `fmt_sel`=1 yields sign/4-bit exponent (bias 7)/3-bit mantissa with no infinity. The output sign bit (bit 7) always equals the input sign bit (bit 15).
- R4: The scaled value is rounded once to the nearest representable byte, with ties going to the even mantissa.
- R5: Results below the smallest normal are encoded as subnormals. Magnitudes up to and including half the smallest subnormal become zero of the input's sign. A ±0 input gives ±0.
- R6: A finite value whose rounded magnitude exceeds the format maximum saturates to magnitude code 0x7B (57344) when `fmt_sel`=0, or 0x7E (448) when `fmt_sel`=1. The sign is kept.
- R7: A NaN input (exponent 31, mantissa nonzero) yields magnitude code 0x7F with the input sign, in both formats.
- R8: An infinite input yields magnitude 0x7C (infinity) when `fmt_sel`=0, and 0x7E (largest finite) when `fmt_sel`=1, with the input sign.
- R9: `out_vld` is `in_vld` delayed by exactly one clock, and `out_data` carries the result of the input accepted on that edge.
- R10: On a clock where `in_vld` is low, `out_data` keeps its previous value whatever the other inputs are.
- R11: While `rst_n` is low, `out_vld` is 0 and `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Accept the current sources |
| src_lo | input | VL | First (even) source vector of half-precision elements |
| src_hi | input | VL | Second (odd) source vector of half-precision elements |
| scale_exp | input | 5 | Signed power-of-two scale |
| fmt_sel | input | 1 | Output byte encoding select |
| out_vld | output | 1 | Result valid |
| out_data | output | VL | Packed 8-bit float results |

## Verification
In a single operation, one lane may saturate while another lane of the same vector flushes to a subnormal or to signed zero. Both outcomes depend on the shared scale, so the bench drives vectors that mix the largest half value with the smallest subnormal and with NaN and infinities, at scales of +15 and -16 in both formats. Each lane is judged against a model that decodes the half value to a real number, scales it, and searches every finite byte code for the nearest value, breaking ties toward the even code. Idle clocks with changing inputs are interleaved with back-to-back valid clocks, so the hold behaviour and the pipeline are checked in the same run.

// File: rtl/fp8np_pkg.sv
package fp8np_pkg;

  typedef enum logic {
    FMT_E5M2 = 1'b0,
    FMT_E4M3 = 1'b1
  } f8fmt_t;

  typedef struct packed {
    logic       sat;
    logic [6:0] mag;
  } narrow_t;

  localparam logic [6:0] MAG_NAN      = 7'h7F;
  localparam logic [6:0] MAG_INF_E5   = 7'h7C;
  localparam logic [6:0] MAG_MAX_E5   = 7'h7B;
  localparam logic [6:0] MAG_MAX_E4   = 7'h7E;

  // Leading zero count of an 11-bit significand (11 when all zero).
  function automatic int lead_zeros(input logic [10:0] v);
    int n;
    n = 11;
    for (int i = 0; i <= 10; i++) begin
      if (v[i]) n = 10 - i;
    end
    return n;
  endfunction

  function automatic int man_bits(input f8fmt_t f);
    return (f == FMT_E4M3) ? 3 : 2;
  endfunction

  function automatic int exp_bias(input f8fmt_t f);
    return (f == FMT_E4M3) ? 7 : 15;
  endfunction

  function automatic logic [6:0] max_mag(input f8fmt_t f);
    return (f == FMT_E4M3) ? MAG_MAX_E4 : MAG_MAX_E5;
  endfunction

  // Narrow a finite, nonzero half magnitude scaled by 2^sc.
  function automatic narrow_t narrow_finite(input logic [4:0]  e5,
                                            input logic [9:0]  m10,
                                            input logic signed [4:0] sc,
                                            input f8fmt_t      f);
    narrow_t    r;
    logic [10:0] sig;
    logic [12:0] wide;
    logic [12:0] low_mask;
    int          ex;
    int          lz;
    int          mb;
    int          bias;
    int          emin;
    int          sh;
    int          q;
    int          code;
    logic        guard;
    logic        sticky;
    if (e5 == 5'd0) begin
      sig = {1'b0, m10};
      ex  = -14;
    end else begin
      sig = {1'b1, m10};
      ex  = int'(e5) - 15;
    end
    lz   = lead_zeros(sig);
    sig  = sig << lz;
    ex   = ex - lz + int'(sc);
    mb   = man_bits(f);
    bias = exp_bias(f);
    emin = 1 - bias;
    sh   = 10 - mb;
    if (ex < emin) sh = sh + (emin - ex);
    if (sh > 12) sh = 12;
    wide     = {2'b00, sig};
    guard    = wide[sh-1];
    low_mask = (13'd1 << (sh - 1)) - 13'd1;
    sticky   = |(wide & low_mask);
    q        = int'(wide >> sh);
    if (guard && (sticky || q[0])) q = q + 1;
    if (ex < emin) code = q;
    else           code = ((ex + bias - 1) << mb) + q;
    r.sat = (code > int'(max_mag(f)));
    r.mag = r.sat ? max_mag(f) : 7'(code);
    return r;
  endfunction

endpackage

// File: rtl/fp8np_lane.sv
module fp8np_lane
  import fp8np_pkg::*;
(
  input  logic [15:0] h_in,
  input  logic [4:0]  scale,
  input  logic        fmt,
  output logic [7:0]  b_out,
  output logic        is_nan,
  output logic        is_inf,
  output logic        is_zero,
  output logic        sat_hit
);

  logic       sgn;
  logic [4:0] e5;
  logic [9:0] m10;
  f8fmt_t     fsel;
  narrow_t    nar;

  assign sgn  = h_in[15];
  assign e5   = h_in[14:10];
  assign m10  = h_in[9:0];
  assign fsel = f8fmt_t'(fmt);

  assign is_nan  = (e5 == 5'h1F) && (m10 != 10'd0);
  assign is_inf  = (e5 == 5'h1F) && (m10 == 10'd0);
  assign is_zero = (e5 == 5'h00) && (m10 == 10'd0);

  assign nar     = narrow_finite(e5, m10, $signed(scale), fsel);
  assign sat_hit = !is_nan && !is_inf && !is_zero && nar.sat;

  always_comb begin
    if (is_nan)       b_out = {sgn, MAG_NAN};
    else if (is_inf)  b_out = {sgn, (fsel == FMT_E4M3) ? MAG_MAX_E4 : MAG_INF_E5};
    else if (is_zero) b_out = {sgn, 7'd0};
    else              b_out = {sgn, nar.mag};
  end

endmodule

// File: rtl/fp8np_out_stage.sv
module fp8np_out_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic         vld_q,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else begin
      vld_q <= ld;
      if (ld) q <= d;
    end
  end

  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> vld_q);
  // R9
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> !vld_q);
  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));

endmodule

// File: rtl/fp8_narrow_pack.sv
module fp8_narrow_pack #(
  parameter int VL = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [VL-1:0] src_lo,
  input  logic [VL-1:0] src_hi,
  input  logic [4:0]    scale_exp,
  input  logic          fmt_sel,
  output logic          out_vld,
  output logic [VL-1:0] out_data
);

  localparam int NE = VL / 16;
  localparam int NB = VL / 8;

  logic [VL-1:0] packed_next;
  logic [NB-1:0] lane_nan;
  logic [NB-1:0] lane_inf;
  logic [NB-1:0] lane_zero;
  logic [NB-1:0] lane_sat;
  logic [NB-1:0] lane_sign;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam int EI = k % NE;
    logic [15:0] h;
    if (k < NE) begin : g_lo
      assign h = src_lo[16*EI +: 16];
    end else begin : g_hi
      assign h = src_hi[16*EI +: 16];
    end
    assign lane_sign[k] = h[15];

    fp8np_lane u_lane (
      .h_in    (h),
      .scale   (scale_exp),
      .fmt     (fmt_sel),
      .b_out   (packed_next[8*k +: 8]),
      .is_nan  (lane_nan[k]),
      .is_inf  (lane_inf[k]),
      .is_zero (lane_zero[k]),
      .sat_hit (lane_sat[k])
    );

    // R7
    nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && lane_nan[k]) |=> (out_data[8*k +: 7] == 7'h7F));
    // R6
    sat_e5_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && lane_sat[k] && !fmt_sel) |=> (out_data[8*k +: 7] == 7'h7B));
    // R6
    sat_e4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (lane_sat[k] || lane_inf[k]) && fmt_sel) |=> (out_data[8*k +: 7] == 7'h7E));
    // R3
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (out_data[8*k+7] == $past(lane_sign[k])));
    // R5
    zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && lane_zero[k]) |=> (out_data[8*k +: 7] == 7'd0));
    // R7
    no_false_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !lane_nan[k]) |=> (out_data[8*k +: 7] != 7'h7F));
  end

  fp8np_out_stage #(.W(VL)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (in_vld),
    .d     (packed_next),
    .vld_q (out_vld),
    .q     (out_data)
  );

endmodule

// File: tb/fp8_narrow_pack_tb_top.sv
`timescale 1ns/1ps
module fp8_narrow_pack_tb_top;

  localparam int VL = 128;
  localparam int NE = VL / 16;
  localparam int NB = VL / 8;
  localparam real TCK = 4.0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [VL-1:0] src_lo = '0;
  logic [VL-1:0] src_hi = '0;
  logic [4:0]    scale_exp = '0;
  logic          fmt_sel = 1'b0;
  logic          out_vld;
  logic [VL-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(TCK/2) clk = ~clk;

  fp8_narrow_pack #(.VL(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_lo(src_lo), .src_hi(src_hi),
    .scale_exp(scale_exp), .fmt_sel(fmt_sel), .out_vld(out_vld), .out_data(out_data)
  );

  // ---------------- behavioural reference ----------------
  function automatic real p2(int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else        repeat (-k) r = r / 2.0;
    return r;
  endfunction

  function automatic real byte_val(int c, bit f);
    int ef, mf;
    if (f) begin
      ef = c / 8; mf = c % 8;
      return (ef == 0) ? mf * p2(-9) : (8 + mf) * p2(ef - 10);
    end
    ef = c / 4; mf = c % 4;
    return (ef == 0) ? mf * p2(-16) : (4 + mf) * p2(ef - 17);
  endfunction

  function automatic real half_mag(logic [15:0] h);
    int e, m;
    e = int'(h[14:10]); m = int'(h[9:0]);
    return (e == 0) ? m * p2(-24) : (1024 + m) * p2(e - 25);
  endfunction

  function automatic int nearest(real a, bit f);
    int best = 0;
    real bd = a;
    real d;
    for (int c = 1; c <= (f ? 126 : 123); c++) begin
      d = byte_val(c, f) - a;
      if (d < 0.0) d = -d;
      if (d < bd || (d == bd && (c % 2) == 0)) begin
        best = c; bd = d;
      end
    end
    return best;
  endfunction

  function automatic logic [7:0] ref_byte(logic [15:0] h, int s, bit f);
    if (h[14:10] == 5'h1F) begin
      if (h[9:0] != 0) return {h[15], 7'h7F};
      return {h[15], f ? 7'h7E : 7'h7C};
    end
    return {h[15], 7'(nearest(half_mag(h) * p2(s), f))};
  endfunction

  function automatic string ref_tag(logic [15:0] h, int s, bit f);
    real a;
    int c;
    if (h[14:10] == 5'h1F) return (h[9:0] != 0) ? "R7" : "R8";
    a = half_mag(h) * p2(s);
    if (a == 0.0) return "R5";
    c = nearest(a, f);
    if (a > byte_val(f ? 126 : 123, f)) return "R6";
    if (c < (f ? 8 : 4)) return "R5";
    if (s != 0) return "R2";
    if (byte_val(c, f) == a) return "R3";
    return "R4";
  endfunction

  logic          m_vld;
  logic [VL-1:0] m_data;
  string         m_tag [NB];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld  = 1'b0;
      m_data = '0;
      for (int k = 0; k < NB; k++) m_tag[k] = "R11";
    end else begin
      m_vld = in_vld;
      if (in_vld) begin
        for (int k = 0; k < NB; k++) begin
          logic [15:0] h;
          h = (k < NE) ? src_lo[16*k +: 16] : src_hi[16*(k-NE) +: 16];
          m_data[8*k +: 8] = ref_byte(h, int'($signed(scale_exp)), fmt_sel);
          m_tag[k] = ref_tag(h, int'($signed(scale_exp)), fmt_sel);
        end
      end else begin
        for (int k = 0; k < NB; k++) m_tag[k] = "R10";
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (out_vld !== m_vld) begin
        n_bad++;
        $display("FAIL R9/R11 out_vld got %b exp %b at %0t", out_vld, m_vld, $time);
      end
      for (int k = 0; k < NB; k++) begin
        n_cmp++;
        if (out_data[8*k +: 8] !== m_data[8*k +: 8]) begin
          n_bad++;
          $display("FAIL %s R1 byte %0d got %h exp %h at %0t",
                   m_tag[k], k, out_data[8*k +: 8], m_data[8*k +: 8], $time);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  logic [15:0] la [NE];
  logic [15:0] ha [NE];

  task automatic put(input logic [4:0] s, input bit f, input bit v);
    @(posedge clk);
    #1;
    for (int i = 0; i < NE; i++) begin
      src_lo[16*i +: 16] = la[i];
      src_hi[16*i +: 16] = ha[i];
    end
    scale_exp = s;
    fmt_sel   = f;
    in_vld    = v;
  endtask

  task automatic load_specials();
    la[0] = 16'h7E00; la[1] = 16'hFE01; la[2] = 16'h7C00; la[3] = 16'hFC00;
    la[4] = 16'h0000; la[5] = 16'h8000; la[6] = 16'h7BFF; la[7] = 16'h0001;
    ha[0] = 16'h0400; ha[1] = 16'h3555; ha[2] = 16'h5BFF; ha[3] = 16'h1234;
    ha[4] = 16'h8001; ha[5] = 16'hC7FF; ha[6] = 16'h3BFF; ha[7] = 16'h4B00;
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin la[i] = 16'h0; ha[i] = 16'h0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // lane placement and ties (1.0 .. 1.875 and negatives), both formats
    for (int i = 0; i < NE; i++) begin
      la[i] = 16'h3C00 + 16'(i * 16'h0080);
      ha[i] = 16'hC000 | 16'(i * 16'h0100);
    end
    put(5'd0, 1'b0, 1'b1);
    put(5'd0, 1'b1, 1'b1);
    put(5'd1, 1'b1, 1'b0);

    // specials at the scale extremes, saturation and flush in one vector
    load_specials();
    put(5'd0,  1'b0, 1'b1);
    put(5'd0,  1'b1, 1'b1);
    put(5'd15, 1'b0, 1'b1);
    put(5'd15, 1'b1, 1'b1);
    put(5'h10, 1'b0, 1'b1);
    put(5'h10, 1'b1, 1'b1);
    put(5'h1F, 1'b1, 1'b1);
    put(5'd3,  1'b0, 1'b0);

    // random traffic with idle gaps whose inputs still toggle
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < NE; i++) begin
        la[i] = 16'($urandom);
        ha[i] = 16'($urandom);
      end
      put(5'($urandom), 1'($urandom), (($urandom % 4) != 0));
    end
    put(5'd0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule